// File: doc/BRIEF.md
# Depth-Cue Color Blend Unit

This block is the color-fogging stage of a fixed-point geometry coprocessor. It takes a source color and pulls it toward a programmable far color by a signed 16-bit blend factor. Every step works on signed fixed-point values with optional 12-bit fraction scaling. The results go into three 32-bit accumulators, three 16-bit intermediate registers, a three-deep color output queue and a status flag word.

Three operations share one datapath. The plain blend uses the color bytes of a 32-bit color word. The lit blend first scales each color byte by the matching intermediate register. The queued blend runs the plain blend three times, and each time it takes its input color from the oldest queue entry. A start strobe latches the opcode, the two mode flags and every operand register. The unit then steps through its pass schedule and pulses a done output once the final values are on its outputs.

Top module: `dcue_unit`

## Requirements
- R1: Opcode 0x10 selects the plain blend, 0x29 the lit blend and 0x2A the queued blend. A start with any other opcode is ignored: no done pulse follows and no output changes.
- R2: First step of each pass, per channel c: the lit blend sets accumulator c to (zero-extended color byte c × signed IR c) × 16. The other two operations set it to color byte × 65536. Color byte c sits at bits [8c+7:8c] of its word.
- R3: Second step: d = far_c × 4096 − accumulator c. If d > 2^43−1, flag bit 30−c is set; if d < −2^43, flag bit 27−c is set. IR c becomes d shifted arithmetically right by 12 when sf is 1 (by 0 otherwise), clamped to −32768..32767 whatever lm is. A clamp sets flag bit 24−c.
- R4: Third step: v = IR c × IR0 + accumulator c, checked for 44-bit overflow with the same flag bits as in R3. Accumulator c becomes the low 32 bits of v shifted arithmetically by the sf amount.
- R5: At the end of each pass, the queue shifts so that entry 1 moves to entry 0 and entry 2 moves to entry 1. The new entry 2 holds byte c = clamp(accumulator c >>> 4, 0..255) with bits [31:24] copied from the color word. Any clamp sets flag bit 21−c. Entry k is at fifo bits [32k+31:32k].
- R6: After the push, IR c is reloaded from accumulator c. The clamp range is 0..32767 when lm is 1 and −32768..32767 when lm is 0, and a clamp sets flag bit 24−c.
- R7: The queued blend makes three passes. Each pass uses the color bytes of the current entry 0.
- R8: The flag word is cleared when an operation is accepted. Bits 30..19 then accumulate across all steps and passes, and bits 18..0 stay 0.
- R9: Flag bit 31 is written once, after the final pass, as the OR of bits 30..19.
- R10: done_o is high for exactly one cycle. It rises 5 clock edges after the accepting edge for the plain and lit blends and 13 edges after it for the queued blend. All outputs hold their final values in that cycle.
- R11: A start that arrives while an operation is running is ignored.
- R12: After reset, all outputs are zero and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, sampled while idle |
| opcode | input | 6 | Operation select |
| sf | input | 1 | Fraction shift enable (12 bits) |
| lm | input | 1 | Non-negative IR clamp on reload |
| rgbc_i | input | 32 | Color word: three color bytes plus code byte |
| ir0_i | input | 16 | Signed blend factor |
| ir_i | input | 48 | Signed IR1..IR3, channel c at [16c+15:16c] |
| far_i | input | 96 | Signed far color, channel c at [32c+31:32c] |
| fifo_i | input | 96 | Initial color queue, entry 0 oldest |
| mac_o | output | 96 | Accumulators, channel c at [32c+31:32c] |
| ir_o | output | 48 | IR1..IR3 |
| fifo_o | output | 96 | Color queue |
| flag_o | output | 32 | Status flags |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Random operations mix all three opcodes, both sf and lm settings, and far colors that are either full-range or small. Full-range far colors drive the IR and color clamps. Small ones keep the arithmetic in range, which shows whether the shift, the multiply and the sign handling are right. Directed cases force positive and negative 44-bit overflow in the second step, a negative result reloaded under lm, color saturation high, and a queued blend with distinct queue entries, which shows whether the right entry feeds each pass. An invalid opcode and a start issued mid-operation show whether the unit ignores requests it should not accept.

// File: rtl/dcue_pkg.sv
package dcue_pkg;
    localparam int CH_N          = 3;
    localparam int COL_W         = 8;
    localparam int IR_W          = 16;
    localparam int MAC_W         = 32;
    localparam int ACC_W         = 44;
    localparam int WIDE_W        = 64;
    localparam int FRAC_SH       = 12;
    localparam int LIGHT_SH      = 4;
    localparam int BASE_SH       = 16;
    localparam int CPACK_SH      = 4;
    localparam int FIFO_D        = 3;
    localparam int OP_W          = 6;
    localparam int TRIPLE_PASSES = 3;
    localparam int FLAG_W        = 32;
    localparam int F_SUM         = 31;
    localparam int F_MPOS        = 30;
    localparam int F_MNEG        = 27;
    localparam int F_IRS         = 24;
    localparam int F_COLS        = 21;
    localparam int F_LOW         = F_COLS - CH_N + 1;

    typedef logic signed [WIDE_W-1:0] wide_t;

    localparam wide_t ACC_MAX = (wide_t'(1) <<< (ACC_W - 1)) - wide_t'(1);
    localparam wide_t ACC_MIN = -(wide_t'(1) <<< (ACC_W - 1));
    localparam wide_t IR_MAX  = (wide_t'(1) <<< (IR_W - 1)) - wide_t'(1);
    localparam wide_t IR_MIN  = -(wide_t'(1) <<< (IR_W - 1));
    localparam wide_t COL_MAX = (wide_t'(1) <<< COL_W) - wide_t'(1);

    typedef enum logic [1:0] {M_SINGLE, M_LIGHT, M_TRIPLE} mode_e;
    typedef enum logic [2:0] {ST_IDLE, ST_SCALE, ST_DIFF, ST_BLEND, ST_PUSH, ST_FIN} step_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } ovf_t;

    typedef struct packed {
        logic            hit;
        logic [IR_W-1:0] val;
    } irsat_t;

    typedef struct packed {
        logic             hit;
        logic [COL_W-1:0] val;
    } colsat_t;

    function automatic ovf_t acc_check(wide_t v);
        ovf_t r;
        r.pos = (v > ACC_MAX);
        r.neg = (v < ACC_MIN);
        return r;
    endfunction

    function automatic irsat_t ir_clamp(wide_t v, logic nonneg);
        irsat_t r;
        wide_t  lo;
        lo = nonneg ? wide_t'(0) : IR_MIN;
        if (v < lo) begin
            r.hit = 1'b1;
            r.val = IR_W'(lo);
        end else if (v > IR_MAX) begin
            r.hit = 1'b1;
            r.val = IR_W'(IR_MAX);
        end else begin
            r.hit = 1'b0;
            r.val = IR_W'(v);
        end
        return r;
    endfunction

    function automatic colsat_t col_clamp(wide_t v);
        colsat_t r;
        if (v < 0) begin
            r.hit = 1'b1;
            r.val = '0;
        end else if (v > COL_MAX) begin
            r.hit = 1'b1;
            r.val = '1;
        end else begin
            r.hit = 1'b0;
            r.val = COL_W'(v);
        end
        return r;
    endfunction
endpackage

// File: rtl/dcue_lane.sv
module dcue_lane
    import dcue_pkg::*;
(
    input  logic                    light,
    input  logic                    sh_en,
    input  logic                    lm,
    input  logic [COL_W-1:0]        col,
    input  logic signed [IR_W-1:0]  ir_cur,
    input  logic signed [IR_W-1:0]  ir0,
    input  logic signed [MAC_W-1:0] far,
    input  logic signed [MAC_W-1:0] mac_cur,
    output logic [MAC_W-1:0]        scale_mac,
    output ovf_t                    scale_ovf,
    output irsat_t                  diff_ir,
    output ovf_t                    diff_ovf,
    output logic [MAC_W-1:0]        blend_mac,
    output ovf_t                    blend_ovf,
    output colsat_t                 push_col,
    output irsat_t                  push_ir
);
    wide_t col_w, ir_w, ir0_w, far_w, mac_w;
    wide_t scale_v, diff_v, blend_v;
    int unsigned sh;

    always_comb begin
        sh      = sh_en ? FRAC_SH : 0;
        col_w   = wide_t'(col);
        ir_w    = wide_t'(ir_cur);
        ir0_w   = wide_t'(ir0);
        far_w   = wide_t'(far);
        mac_w   = wide_t'(mac_cur);

        scale_v   = light ? ((col_w * ir_w) <<< LIGHT_SH) : (col_w <<< BASE_SH);
        scale_mac = MAC_W'(scale_v);
        scale_ovf = acc_check(scale_v);

        diff_v    = (far_w <<< FRAC_SH) - mac_w;
        diff_ovf  = acc_check(diff_v);
        diff_ir   = ir_clamp(diff_v >>> sh, 1'b0);

        blend_v   = ir_w * ir0_w + mac_w;
        blend_ovf = acc_check(blend_v);
        blend_mac = MAC_W'(blend_v >>> sh);

        push_col  = col_clamp(mac_w >>> CPACK_SH);
        push_ir   = ir_clamp(mac_w, lm);
    end
endmodule

// File: rtl/dcue_fifo.sv
module dcue_fifo #(
    parameter int DEPTH = 3,
    parameter int W     = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [DEPTH*W-1:0] load_data,
    input  logic               push,
    input  logic [W-1:0]       push_data,
    output logic [DEPTH*W-1:0] q
);
    logic [W-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [W-1:0] shift_in;
        if (i == DEPTH - 1) begin : g_tail
            assign shift_in = push_data;
        end else begin : g_body
            assign shift_in = ent[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst)       ent[i] <= '0;
            else if (load) ent[i] <= load_data[W*i +: W];
            else if (push) ent[i] <= shift_in;
        end

        assign q[W*i +: W] = ent[i];
    end
endmodule

// File: rtl/dcue_ctrl.sv
module dcue_ctrl
    import dcue_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  op_ok,
    input  logic  triple,
    output step_e step,
    output logic  accept,
    output logic  done
);
    localparam int PW = (TRIPLE_PASSES > 1) ? $clog2(TRIPLE_PASSES) : 1;

    step_e         st;
    logic [PW-1:0] pass_q;

    assign step   = st;
    assign accept = (st == ST_IDLE) && start && op_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            pass_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (accept) begin
                    st     <= ST_SCALE;
                    pass_q <= '0;
                end
                ST_SCALE: st <= ST_DIFF;
                ST_DIFF:  st <= ST_BLEND;
                ST_BLEND: st <= ST_PUSH;
                ST_PUSH: begin
                    if (triple && (pass_q != PW'(TRIPLE_PASSES - 1))) begin
                        pass_q <= pass_q + 1'b1;
                        st     <= ST_SCALE;
                    end else begin
                        st <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dcue_unit.sv
module dcue_unit
    import dcue_pkg::*;
#(
    parameter logic [OP_W-1:0] OP_SINGLE = 6'h10,
    parameter logic [OP_W-1:0] OP_LIGHT  = 6'h29,
    parameter logic [OP_W-1:0] OP_TRIPLE = 6'h2A
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [OP_W-1:0]         opcode,
    input  logic                    sf,
    input  logic                    lm,
    input  logic [MAC_W-1:0]        rgbc_i,
    input  logic [IR_W-1:0]         ir0_i,
    input  logic [CH_N*IR_W-1:0]    ir_i,
    input  logic [CH_N*MAC_W-1:0]   far_i,
    input  logic [FIFO_D*MAC_W-1:0] fifo_i,
    output logic [CH_N*MAC_W-1:0]   mac_o,
    output logic [CH_N*IR_W-1:0]    ir_o,
    output logic [FIFO_D*MAC_W-1:0] fifo_o,
    output logic [FLAG_W-1:0]       flag_o,
    output logic                    done_o
);
    mode_e                   mode_d, mode_q;
    logic                    op_ok, accept, push_en;
    step_e                   step;
    logic                    sf_q, lm_q;
    logic [MAC_W-1:0]        rgbc_q;
    logic signed [IR_W-1:0]  ir0_q;
    logic signed [IR_W-1:0]  ir_q  [CH_N];
    logic signed [MAC_W-1:0] far_q [CH_N];
    logic signed [MAC_W-1:0] mac_q [CH_N];
    logic [FLAG_W-1:0]       flag_q, flag_nxt;
    logic [MAC_W-1:0]        push_word;

    logic [MAC_W-1:0] scale_mac [CH_N];
    logic [MAC_W-1:0] blend_mac [CH_N];
    ovf_t             scale_ovf [CH_N];
    ovf_t             diff_ovf  [CH_N];
    ovf_t             blend_ovf [CH_N];
    irsat_t           diff_ir   [CH_N];
    irsat_t           push_ir   [CH_N];
    colsat_t          push_col  [CH_N];

    always_comb begin
        op_ok  = 1'b1;
        mode_d = M_SINGLE;
        case (opcode)
            OP_SINGLE: mode_d = M_SINGLE;
            OP_LIGHT:  mode_d = M_LIGHT;
            OP_TRIPLE: mode_d = M_TRIPLE;
            default:   op_ok  = 1'b0;
        endcase
    end

    dcue_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op_ok  (op_ok),
        .triple (mode_q == M_TRIPLE),
        .step   (step),
        .accept (accept),
        .done   (done_o)
    );

    assign push_en = (step == ST_PUSH);

    for (genvar c = 0; c < CH_N; c++) begin : g_lane
        logic [COL_W-1:0] col_src;
        assign col_src = (mode_q == M_TRIPLE) ? fifo_o[COL_W*c +: COL_W]
                                              : rgbc_q[COL_W*c +: COL_W];
        dcue_lane u_lane (
            .light     (mode_q == M_LIGHT),
            .sh_en     (sf_q),
            .lm        (lm_q),
            .col       (col_src),
            .ir_cur    (ir_q[c]),
            .ir0       (ir0_q),
            .far       (far_q[c]),
            .mac_cur   (mac_q[c]),
            .scale_mac (scale_mac[c]),
            .scale_ovf (scale_ovf[c]),
            .diff_ir   (diff_ir[c]),
            .diff_ovf  (diff_ovf[c]),
            .blend_mac (blend_mac[c]),
            .blend_ovf (blend_ovf[c]),
            .push_col  (push_col[c]),
            .push_ir   (push_ir[c])
        );
        assign push_word[COL_W*c +: COL_W] = push_col[c].val;
        assign mac_o[MAC_W*c +: MAC_W]     = mac_q[c];
        assign ir_o[IR_W*c +: IR_W]        = ir_q[c];
    end
    assign push_word[MAC_W-1 -: COL_W] = rgbc_q[MAC_W-1 -: COL_W];

    dcue_fifo #(.DEPTH(FIFO_D), .W(MAC_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_data (fifo_i),
        .push      (push_en),
        .push_data (push_word),
        .q         (fifo_o)
    );

    always_comb begin
        flag_nxt = flag_q;
        for (int c = 0; c < CH_N; c++) begin
            case (step)
                ST_SCALE: begin
                    flag_nxt[F_MPOS-c] = flag_q[F_MPOS-c] | scale_ovf[c].pos;
                    flag_nxt[F_MNEG-c] = flag_q[F_MNEG-c] | scale_ovf[c].neg;
                end
                ST_DIFF: begin
                    flag_nxt[F_MPOS-c] = flag_q[F_MPOS-c] | diff_ovf[c].pos;
                    flag_nxt[F_MNEG-c] = flag_q[F_MNEG-c] | diff_ovf[c].neg;
                    flag_nxt[F_IRS-c]  = flag_q[F_IRS-c]  | diff_ir[c].hit;
                end
                ST_BLEND: begin
                    flag_nxt[F_MPOS-c] = flag_q[F_MPOS-c] | blend_ovf[c].pos;
                    flag_nxt[F_MNEG-c] = flag_q[F_MNEG-c] | blend_ovf[c].neg;
                end
                ST_PUSH: begin
                    flag_nxt[F_IRS-c]  = flag_q[F_IRS-c]  | push_ir[c].hit;
                    flag_nxt[F_COLS-c] = flag_q[F_COLS-c] | push_col[c].hit;
                end
                default: ;
            endcase
        end
        if (step == ST_FIN) flag_nxt[F_SUM] = |flag_q[F_MPOS:F_LOW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_SINGLE;
            sf_q   <= 1'b0;
            lm_q   <= 1'b0;
            rgbc_q <= '0;
            ir0_q  <= '0;
            flag_q <= '0;
            for (int c = 0; c < CH_N; c++) begin
                ir_q[c]  <= '0;
                far_q[c] <= '0;
                mac_q[c] <= '0;
            end
        end else if (accept) begin
            mode_q <= mode_d;
            sf_q   <= sf;
            lm_q   <= lm;
            rgbc_q <= rgbc_i;
            ir0_q  <= ir0_i;
            flag_q <= '0;
            for (int c = 0; c < CH_N; c++) begin
                ir_q[c]  <= ir_i[IR_W*c +: IR_W];
                far_q[c] <= far_i[MAC_W*c +: MAC_W];
            end
        end else begin
            flag_q <= flag_nxt;
            for (int c = 0; c < CH_N; c++) begin
                case (step)
                    ST_SCALE: mac_q[c] <= scale_mac[c];
                    ST_DIFF:  ir_q[c]  <= diff_ir[c].val;
                    ST_BLEND: mac_q[c] <= blend_mac[c];
                    ST_PUSH:  ir_q[c]  <= push_ir[c].val;
                    default: ;
                endcase
            end
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/dcue_chk.sv
module dcue_chk (
    input logic        clk,
    input logic        rst,
    input logic        done_o,
    input logic        accept,
    input logic        push_en,
    input logic [12:0] flag_hi,
    input logic [95:0] fifo_o
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    summary_bit_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (flag_hi[12] == (|flag_hi[11:0])));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (flag_hi == 13'd0));

    // R5
    fifo_shift_chk: assert property (@(posedge clk) disable iff (rst)
        push_en |=> (fifo_o[63:0] == $past(fifo_o[95:32])));

    // R11
    busy_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);
endmodule

bind dcue_unit dcue_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .done_o  (done_o),
    .accept  (accept),
    .push_en (push_en),
    .flag_hi (flag_o[31:19]),
    .fifo_o  (fifo_o)
);

// File: tb/tb_dcue_unit.sv
`timescale 1ns/1ps
module tb_dcue_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  opcode = '0;
    logic        sf = 1'b0, lm = 1'b0;
    logic [31:0] rgbc_i = '0;
    logic [15:0] ir0_i = '0;
    logic [47:0] ir_i = '0;
    logic [95:0] far_i = '0, fifo_i = '0;
    logic [95:0] mac_o, fifo_o;
    logic [47:0] ir_o;
    logic [31:0] flag_o;
    logic        done_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dcue_unit dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .sf(sf), .lm(lm),
        .rgbc_i(rgbc_i), .ir0_i(ir0_i), .ir_i(ir_i), .far_i(far_i), .fifo_i(fifo_i),
        .mac_o(mac_o), .ir_o(ir_o), .fifo_o(fifo_o), .flag_o(flag_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input logic [95:0] got, input logic [95:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] fmac(logic [31:0] fl, longint v, int c);
        logic [31:0] r = fl;
        if (v > 64'sh7FF_FFFF_FFFF) r[30-c] = 1'b1;
        if (v < -64'sh800_0000_0000) r[27-c] = 1'b1;
        return r;
    endfunction

    function automatic logic irhit(longint v, logic nn);
        longint lo = nn ? 0 : -32768;
        return (v < lo) || (v > 32767);
    endfunction

    function automatic logic [15:0] irval(longint v, logic nn);
        longint lo = nn ? 0 : -32768;
        if (v < lo) return 16'(lo);
        if (v > 32767) return 16'h7FFF;
        return 16'(v);
    endfunction

    task automatic model(input logic [5:0] op, input logic sfv, input logic lmv,
                         input logic [31:0] rgbc, input logic [15:0] ir0,
                         input logic [47:0] irv, input logic [95:0] farv, input logic [95:0] fifov,
                         output logic [95:0] emac, output logic [47:0] eir,
                         output logic [95:0] efifo, output logic [31:0] eflag);
        logic signed [31:0] m [3];
        logic signed [15:0] ir [3];
        logic [31:0] f [3];
        logic [7:0]  cb [3];
        logic [7:0]  cin;
        longint v, cv;
        int sh, np;
        sh = sfv ? 12 : 0;
        np = (op == 6'h2A) ? 3 : 1;
        eflag = '0;
        for (int c = 0; c < 3; c++) begin
            ir[c] = irv[16*c +: 16];
            f[c]  = fifov[32*c +: 32];
            m[c]  = '0;
        end
        for (int p = 0; p < np; p++) begin
            for (int c = 0; c < 3; c++) begin
                cin = (op == 6'h2A) ? f[0][8*c +: 8] : rgbc[8*c +: 8];
                if (op == 6'h29) v = longint'(cin) * longint'(ir[c]) * 16;
                else             v = longint'(cin) * 65536;
                eflag = fmac(eflag, v, c);
                m[c] = v[31:0];
                v = longint'($signed(farv[32*c +: 32])) * 4096 - longint'(m[c]);
                eflag = fmac(eflag, v, c);
                v = v >>> sh;
                if (irhit(v, 1'b0)) eflag[24-c] = 1'b1;
                ir[c] = irval(v, 1'b0);
                v = longint'(ir[c]) * longint'($signed(ir0)) + longint'(m[c]);
                eflag = fmac(eflag, v, c);
                v = v >>> sh;
                m[c] = v[31:0];
                cv = longint'(m[c]) >>> 4;
                if (cv < 0)        begin cb[c] = 8'h00; eflag[21-c] = 1'b1; end
                else if (cv > 255) begin cb[c] = 8'hFF; eflag[21-c] = 1'b1; end
                else               cb[c] = 8'(cv);
                if (irhit(longint'(m[c]), lmv)) eflag[24-c] = 1'b1;
                ir[c] = irval(longint'(m[c]), lmv);
            end
            f[0] = f[1];
            f[1] = f[2];
            f[2] = {rgbc[31:24], cb[2], cb[1], cb[0]};
        end
        eflag[31] = |eflag[30:19];
        for (int c = 0; c < 3; c++) begin
            emac[32*c +: 32]  = m[c];
            eir[16*c +: 16]   = ir[c];
            efifo[32*c +: 32] = f[c];
        end
    endtask

    task automatic run_op(input string tag, input logic [5:0] op, input logic sfv, input logic lmv,
                          input logic [31:0] rgbc, input logic [15:0] ir0, input logic [47:0] irv,
                          input logic [95:0] farv, input logic [95:0] fifov, input bit inject);
        logic [95:0] emac, efifo;
        logic [47:0] eir;
        logic [31:0] eflag;
        int cyc, exp_lat;
        model(op, sfv, lmv, rgbc, ir0, irv, farv, fifov, emac, eir, efifo, eflag);
        exp_lat = (op == 6'h2A) ? 13 : 5;
        @(negedge clk);
        opcode = op; sf = sfv; lm = lmv; rgbc_i = rgbc; ir0_i = ir0;
        ir_i = irv; far_i = farv; fifo_i = fifov; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 2) begin
                opcode = 6'h10; rgbc_i = ~rgbc; ir0_i = ~ir0; far_i = ~farv;
                fifo_i = ~fifov; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        chk({tag, " R10 latency"}, 96'(cyc), 96'(exp_lat));
        chk({tag, " mac"}, mac_o, emac);
        chk({tag, " R6 ir"}, 96'(ir_o), 96'(eir));
        chk({tag, " R5 fifo"}, fifo_o, efifo);
        chk({tag, " R8 flag"}, 96'(flag_o), 96'(eflag));
        chk({tag, " R9 summary"}, 96'(flag_o[31]), 96'(|eflag[30:19]));
        @(negedge clk);
        chk({tag, " R10 done low"}, 96'(done_o), 96'(0));
    endtask

    function automatic logic [95:0] rnd96();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    initial begin : watchdog
        #1_000_000;
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [95:0] farv, sm, sf_snap, sfifo;
        logic [47:0] sir;
        logic [31:0] sflag;
        logic [5:0]  ops [3];
        bit seen;
        string tg;
        void'($urandom(32'd1234));
        ops[0] = 6'h10; ops[1] = 6'h29; ops[2] = 6'h2A;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk("R12 mac", mac_o, '0);
        chk("R12 ir", 96'(ir_o), '0);
        chk("R12 fifo", fifo_o, '0);
        chk("R12 flag/done", 96'({flag_o, done_o}), '0);

        // R3: negative 44-bit overflow in the difference step
        run_op("R3 neg", 6'h10, 1'b1, 1'b0, 32'h00102030, 16'h0800, 48'h0,
               {3{32'h80000000}}, 96'h0, 0);
        // R3: positive overflow via lit blend with negative IR (R2)
        run_op("R3 pos R2", 6'h29, 1'b0, 1'b0, 32'h11FFFFFF, 16'h0100, {3{16'hFFFE}},
               {3{32'h7FFFFFFF}}, 96'h0, 0);
        // R6: negative result reloaded under lm clamps to zero
        run_op("R6 lm", 6'h10, 1'b1, 1'b1, 32'h80FF7F01, 16'h1000, 48'h0,
               {3{32'hFFFFFC18}}, 96'h0, 0);
        // R5: color saturates high
        run_op("R5 colhi", 6'h10, 1'b1, 1'b0, 32'h5A000000, 16'h1000, 48'h0,
               {3{32'h00010000}}, 96'h0, 0);
        // R7: queued blend with distinct entries
        run_op("R7 queue", 6'h2A, 1'b1, 1'b0, 32'hC3000000, 16'h0400, 48'h0,
               {32'h0000FF00, 32'h00000A0B, 32'h00102030, 32'h00405060},
               {32'h00302010, 32'h00605040, 32'h00A0B0C0}, 0);
        // R11: start during operation ignored
        run_op("R11 busy", 6'h2A, 1'b0, 1'b1, 32'h7E112233, 16'h0C00, 48'h000100020003,
               {3{32'h00000010}}, {32'h00445566, 32'h00778899, 32'h00AABBCC}, 1);

        // R1: unknown opcode ignored
        sm = mac_o; sir = ir_o; sfifo = fifo_o; sflag = flag_o;
        @(negedge clk);
        opcode = 6'h11; rgbc_i = 32'hFFFFFFFF; far_i = rnd96(); fifo_i = rnd96(); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (done_o) seen = 1;
        end
        chk("R1 no done", 96'(seen), 96'(0));
        sf_snap = {sflag, 64'h0};
        chk("R1 mac kept", mac_o, sm);
        chk("R1 ir kept", 96'(ir_o), 96'(sir));
        chk("R1 fifo kept", fifo_o, sfifo);
        chk("R1 flag kept", {flag_o, 64'h0}, sf_snap);

        // random mix
        for (int k = 0; k < 60; k++) begin
            logic [5:0] op;
            op = ops[$urandom_range(0, 2)];
            farv = rnd96();
            if ($urandom_range(0, 1) == 1) begin
                for (int c = 0; c < 3; c++)
                    farv[32*c +: 32] = 32'(int'($urandom_range(0, 8191)) - 4096);
            end
            tg = (op == 6'h10) ? "R4 rnd" : (op == 6'h29) ? "R2 rnd" : "R7 rnd";
            run_op(tg, op, 1'($urandom()), 1'($urandom()), $urandom(), 16'($urandom()),
                   48'(rnd96()), farv, rnd96(), 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule